// File: doc/BRIEF.md
# CAN Receive Acceptance Filter

This block decides which receive message center, if any, should take a CAN frame that has just been received. It holds no frames. It compares the identifier, format flag, data length and first two payload bytes of the frame against fifteen center configurations and one set of global masks. One clock after the frame-valid strobe it reports a match flag and the number of the center that wins.

Each center has its own settings: a 29-bit arbitration value, a standard/extended selector, a direction bit, an enable for the global masks and an enable for the payload-byte test. The payload-byte test compares data bytes 0 and 1 against two per-center reference bytes. It lets a higher-layer protocol that carries part of its addressing in the payload filter frames before they are stored. Center 15 is a receive-only center, so its direction bit is ignored.

Centers are numbered 1 to 15. Center n uses bit n-1 of every per-center vector, and bits (n-1)*29 and (n-1)*8 upward of the packed arbitration and reference-byte vectors.

Top module: `can_accept_filter`

## Requirements
- R1: After reset, `match_vld` is 0 and `match_idx` is 0.
- R2: A receive center whose format bit equals the frame's format, and whose identifier and payload tests pass, is reported with its 1-based number in `match_idx`.
- R3: A center whose format bit (1 = 29-bit extended, 0 = 11-bit standard) differs from `frm_ext` never matches, even when the identifier bits are equal.
- R4: When a center's `ctr_gmask_en` bit is 1, identifier bits where `gid_mask` is 0 are don't-care, and bits where it is 1 must be equal.
- R5: When a center's `ctr_gmask_en` bit is 0, every identifier bit in use must be equal, whatever `gid_mask` holds. The payload bytes must then also be equal on all 8 bits when the payload test is enabled.
- R6: A center with its `ctr_tx` bit at 1 (transmit) never matches, except center 15, whose `ctr_tx` bit has no effect.
- R7: When several centers match, `match_idx` reports the lowest-numbered one.
- R8: With `ctr_media_en` set, data byte 0 is compared with the center's reference byte 0 under mask `gmed_mask0`, and byte 1 with reference byte 1 under `gmed_mask1`. A mask bit of 1 means compare, or all bits are compared when the global masks are off for the center. Any mismatch rejects the center.
- R9: With the payload test enabled, a frame must carry at least 2 data bytes if any bit of the effective byte-1 mask is 1. Otherwise it must carry at least 1 byte if any bit of the effective byte-0 mask is 1. Shorter frames fail the test. A length code above 8 counts as 8.
- R10: `match_vld` and `match_idx` are registered. They reflect the frame presented with `frm_valid` at one rising edge, are visible after that edge, and drop to 0 on the next edge if `frm_valid` is low.
- R11: For a standard-format frame only identifier bits 10:0 are compared; bits 28:11 of `frm_id` and of the arbitration value have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid | input | 1 | Frame fields are valid this cycle |
| frm_id | input | 29 | Received identifier (standard uses bits 10:0) |
| frm_ext | input | 1 | 1 = extended frame, 0 = standard |
| frm_dlc | input | 4 | Data length code |
| frm_b0 | input | 8 | First data byte |
| frm_b1 | input | 8 | Second data byte |
| gid_mask | input | 29 | Global identifier mask, 1 = compare |
| gmed_mask0 | input | 8 | Global mask for data byte 0 |
| gmed_mask1 | input | 8 | Global mask for data byte 1 |
| ctr_arb | input | 435 | Packed per-center arbitration values |
| ctr_ref0 | input | 120 | Packed per-center reference byte 0 |
| ctr_ref1 | input | 120 | Packed per-center reference byte 1 |
| ctr_ext | input | 15 | Per-center format, 1 = extended |
| ctr_tx | input | 15 | Per-center direction, 1 = transmit |
| ctr_gmask_en | input | 15 | Per-center use of global masks |
| ctr_media_en | input | 15 | Per-center payload-byte test enable |
| match_vld | output | 1 | A center accepted the last frame |
| match_idx | output | 4 | Winning center number 1..15, 0 if none |

## Verification
On every cycle the assertions check the registered output contract. A valid result appears only after a frame strobe. An idle result carries index 0, and a reported index lies in 1..15. The winning center, as configured in the strobe cycle, must be a receive center of the frame's format. Whether the right center was chosen depends on masks, payload bytes, data length and priority among several candidates. That only shows when the bench's scenarios are compared with its reference model: directed frames that sit at each mask, length and format boundary, then a long run of random configurations.

// File: rtl/can_accept_filter.sv
module can_accept_filter #(
  parameter int NCTR = 15,
  parameter int IDW  = 29,
  parameter int STDW = 11,
  parameter int BW   = 8,
  parameter int DLCW = 4,
  parameter int IXW  = $clog2(NCTR + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frm_valid,
  input  logic [IDW-1:0]       frm_id,
  input  logic                 frm_ext,
  input  logic [DLCW-1:0]      frm_dlc,
  input  logic [BW-1:0]        frm_b0,
  input  logic [BW-1:0]        frm_b1,
  input  logic [IDW-1:0]       gid_mask,
  input  logic [BW-1:0]        gmed_mask0,
  input  logic [BW-1:0]        gmed_mask1,
  input  logic [NCTR*IDW-1:0]  ctr_arb,
  input  logic [NCTR*BW-1:0]   ctr_ref0,
  input  logic [NCTR*BW-1:0]   ctr_ref1,
  input  logic [NCTR-1:0]      ctr_ext,
  input  logic [NCTR-1:0]      ctr_tx,
  input  logic [NCTR-1:0]      ctr_gmask_en,
  input  logic [NCTR-1:0]      ctr_media_en,
  output logic                 match_vld,
  output logic [IXW-1:0]       match_idx
);

  localparam logic [DLCW-1:0] MAXLEN = DLCW'(8);

  logic [NCTR-1:0] hit;
  logic [IXW-1:0]  win;
  logic [DLCW-1:0] dlc_eff;
  logic [IDW-1:0]  fmt_bits;

  assign dlc_eff  = (frm_dlc > MAXLEN) ? MAXLEN : frm_dlc;
  assign fmt_bits = frm_ext ? {IDW{1'b1}} : {{(IDW-STDW){1'b0}}, {STDW{1'b1}}};

  for (genvar g = 0; g < NCTR; g++) begin : g_ctr
    logic [IDW-1:0]  arb, idm;
    logic [BW-1:0]   m0, m1;
    logic [DLCW-1:0] need;
    logic            id_ok, med_ok, is_rx;

    assign arb    = ctr_arb[g*IDW +: IDW];
    assign idm    = (ctr_gmask_en[g] ? gid_mask : {IDW{1'b1}}) & fmt_bits;
    assign id_ok  = ((frm_id ^ arb) & idm) == '0;
    assign m0     = ctr_gmask_en[g] ? gmed_mask0 : {BW{1'b1}};
    assign m1     = ctr_gmask_en[g] ? gmed_mask1 : {BW{1'b1}};
    assign need   = (|m1) ? DLCW'(2) : (|m0) ? DLCW'(1) : DLCW'(0);
    assign med_ok = !ctr_media_en[g] ||
                    ((dlc_eff >= need) &&
                     (((frm_b0 ^ ctr_ref0[g*BW +: BW]) & m0) == '0) &&
                     (((frm_b1 ^ ctr_ref1[g*BW +: BW]) & m1) == '0));
    if (g == NCTR - 1) begin : g_rxonly
      assign is_rx = 1'b1;
    end else begin : g_dir
      assign is_rx = !ctr_tx[g];
    end
    assign hit[g] = is_rx && (ctr_ext[g] == frm_ext) && id_ok && med_ok;
  end

  always_comb begin
    win = '0;
    for (int i = NCTR - 1; i >= 0; i--)
      if (hit[i]) win = IXW'(i + 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_vld <= 1'b0;
      match_idx <= '0;
    end else if (frm_valid) begin
      match_vld <= |hit;
      match_idx <= win;
    end else begin
      match_vld <= 1'b0;
      match_idx <= '0;
    end
  end

  // R10
  vld_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_vld |-> $past(frm_valid));

  // R1
  idle_idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !match_vld |-> match_idx == '0);

  // R2
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_vld |-> (match_idx != '0) && (match_idx <= IXW'(NCTR)));

  // R6
  tx_never_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_vld && match_idx < IXW'(NCTR)) |->
      !(($past(ctr_tx) >> (match_idx - IXW'(1))) & NCTR'(1)));

  // R3
  fmt_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_vld |-> ((($past(ctr_ext) >> (match_idx - IXW'(1))) & NCTR'(1)) != '0) == $past(frm_ext));

endmodule

// File: tb/can_accept_filter_tb.sv
`timescale 1ns/1ps
module can_accept_filter_tb;
  localparam int N = 15;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic        frm_valid = 0, frm_ext = 0;
  logic [28:0] frm_id = 0, gid_mask = '1;
  logic [3:0]  frm_dlc = 0;
  logic [7:0]  frm_b0 = 0, frm_b1 = 0, gmed_mask0 = '1, gmed_mask1 = '1;
  logic [28:0] arb [N];
  logic [7:0]  r0 [N], r1 [N];
  logic        c_ext [N], c_tx [N], c_gm [N], c_me [N];
  logic [N*29-1:0] ctr_arb;
  logic [N*8-1:0]  ctr_ref0, ctr_ref1;
  logic [N-1:0]    ctr_ext, ctr_tx, ctr_gmask_en, ctr_media_en;
  logic        match_vld;
  logic [3:0]  match_idx;

  always_comb
    for (int c = 0; c < N; c++) begin
      ctr_arb[c*29 +: 29] = arb[c];
      ctr_ref0[c*8 +: 8]  = r0[c];
      ctr_ref1[c*8 +: 8]  = r1[c];
      ctr_ext[c] = c_ext[c]; ctr_tx[c] = c_tx[c];
      ctr_gmask_en[c] = c_gm[c]; ctr_media_en[c] = c_me[c];
    end

  can_accept_filter u_dut (.clk, .rst_n, .frm_valid, .frm_id, .frm_ext, .frm_dlc,
    .frm_b0, .frm_b1, .gid_mask, .gmed_mask0, .gmed_mask1, .ctr_arb, .ctr_ref0,
    .ctr_ref1, .ctr_ext, .ctr_tx, .ctr_gmask_en, .ctr_media_en, .match_vld, .match_idx);

  int checks = 0, fails = 0;
  string cur_req = "R1";

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_pick();
    int len;
    len = (frm_dlc > 8) ? 8 : int'(frm_dlc);
    for (int c = 0; c < N; c++) begin
      bit ok = 1;
      int bits, need;
      logic [7:0] m0, m1;
      if (c_tx[c] && c != N - 1) ok = 0;
      if (c_ext[c] != frm_ext) ok = 0;
      bits = frm_ext ? 29 : 11;
      for (int b = 0; b < bits; b++)
        if ((!c_gm[c] || gid_mask[b]) && frm_id[b] != arb[c][b]) ok = 0;
      if (c_me[c]) begin
        m0 = c_gm[c] ? gmed_mask0 : 8'hFF;
        m1 = c_gm[c] ? gmed_mask1 : 8'hFF;
        need = 0;
        if (m0 != 0) need = 1;
        if (m1 != 0) need = 2;
        if (len < need) ok = 0;
        for (int b = 0; b < 8; b++) begin
          if (m0[b] && frm_b0[b] != r0[c][b]) ok = 0;
          if (m1[b] && frm_b1[b] != r1[c][b]) ok = 0;
        end
      end
      if (ok) return c + 1;
    end
    return 0;
  endfunction

  int exp_idx = 0;
  always @(posedge clk) begin
    if (!rst_n || !frm_valid) exp_idx = 0;
    else exp_idx = ref_pick();
  end

  always @(negedge clk)
    if (rst_n) begin
      chk(match_vld == (exp_idx != 0), {cur_req, " vld"}, int'(match_vld), int'(exp_idx != 0));
      chk(int'(match_idx) == exp_idx, {cur_req, " idx"}, int'(match_idx), exp_idx);
    end

  task automatic clear_cfg();
    gid_mask = '1; gmed_mask0 = '1; gmed_mask1 = '1;
    for (int c = 0; c < N; c++) begin
      arb[c] = 29'h1ABCDEF0 + 29'(c); r0[c] = 0; r1[c] = 0;
      c_ext[c] = 1; c_tx[c] = 1; c_gm[c] = 0; c_me[c] = 0;
    end
  endtask

  task automatic set_rx(input int n, input logic [28:0] a, input logic e);
    arb[n-1] = a; c_ext[n-1] = e; c_tx[n-1] = 0;
  endtask

  int got;
  task automatic send(input logic [28:0] id, input logic e, input logic [3:0] dlc,
                      input logic [7:0] b0, input logic [7:0] b1);
    frm_id = id; frm_ext = e; frm_dlc = dlc; frm_b0 = b0; frm_b1 = b1; frm_valid = 1;
    @(negedge clk);
    frm_valid = 0;
    got = match_vld ? int'(match_idx) : 0;
    @(negedge clk);
  endtask

  task automatic expect_idx(input string req, input int e);
    chk(got == e, req, got, e);
  endtask

  initial begin
    #1000000;
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    clear_cfg();
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(match_vld == 0 && match_idx == 0, "R1", int'(match_idx), 0);
    @(negedge clk);

    cur_req = "R2"; clear_cfg(); set_rx(5, 29'h123, 0);
    send(29'h123, 0, 0, 0, 0); expect_idx("R2", 5);
    send(29'h124, 0, 0, 0, 0); expect_idx("R2", 0);
    set_rx(9, 29'h0ABCDEF, 1);
    send(29'h0ABCDEF, 1, 8, 0, 0); expect_idx("R2", 9);

    cur_req = "R3"; clear_cfg(); set_rx(3, 29'h055, 1);
    send(29'h055, 0, 0, 0, 0); expect_idx("R3", 0);
    c_ext[2] = 0; send(29'h055, 0, 0, 0, 0); expect_idx("R3", 3);

    cur_req = "R4"; clear_cfg(); set_rx(4, 29'h700, 0); c_gm[3] = 1;
    gid_mask = 29'h700;
    send(29'h7FF, 0, 0, 0, 0); expect_idx("R4", 4);
    send(29'h6FF, 0, 0, 0, 0); expect_idx("R4", 0);

    cur_req = "R5"; c_gm[3] = 0;
    send(29'h7FF, 0, 0, 0, 0); expect_idx("R5", 0);
    send(29'h700, 0, 0, 0, 0); expect_idx("R5", 4);
    c_me[3] = 1; r0[3] = 8'h5A; r1[3] = 8'hA5; gmed_mask0 = 0; gmed_mask1 = 0;
    send(29'h700, 0, 2, 8'h5B, 8'hA5); expect_idx("R5", 0);

    cur_req = "R6"; clear_cfg(); set_rx(2, 29'h010, 0); c_tx[1] = 1;
    send(29'h010, 0, 0, 0, 0); expect_idx("R6", 0);
    arb[14] = 29'h010; c_ext[14] = 0; c_tx[14] = 1;
    send(29'h010, 0, 0, 0, 0); expect_idx("R6", 15);

    cur_req = "R7"; clear_cfg(); set_rx(11, 29'h222, 0); set_rx(7, 29'h222, 0);
    set_rx(12, 29'h222, 0);
    send(29'h222, 0, 0, 0, 0); expect_idx("R7", 7);

    cur_req = "R8"; clear_cfg(); set_rx(6, 29'h300, 0); c_gm[5] = 1; c_me[5] = 1;
    r0[5] = 8'h12; r1[5] = 8'h34; gmed_mask0 = 8'hF0; gmed_mask1 = 8'hFF;
    send(29'h300, 0, 2, 8'h1F, 8'h34); expect_idx("R8", 6);
    send(29'h300, 0, 2, 8'h22, 8'h34); expect_idx("R8", 0);
    send(29'h300, 0, 2, 8'h12, 8'h35); expect_idx("R8", 0);

    cur_req = "R9";
    send(29'h300, 0, 1, 8'h12, 8'h34); expect_idx("R9", 0);
    gmed_mask1 = 0;
    send(29'h300, 0, 1, 8'h12, 8'h00); expect_idx("R9", 6);
    send(29'h300, 0, 0, 8'h12, 8'h00); expect_idx("R9", 0);
    gmed_mask0 = 0;
    send(29'h300, 0, 0, 8'h00, 8'h00); expect_idx("R9", 6);
    gmed_mask1 = 8'h01;
    send(29'h300, 0, 4'd12, 8'h00, 8'h34); expect_idx("R9", 6);

    cur_req = "R10"; clear_cfg(); set_rx(1, 29'h001, 0);
    frm_id = 29'h001; frm_ext = 0; frm_valid = 0;
    @(negedge clk);
    chk(match_vld == 0, "R10 no strobe", int'(match_vld), 0);
    send(29'h001, 0, 0, 0, 0); expect_idx("R10", 1);
    chk(match_vld == 0, "R10 drop", int'(match_vld), 0);

    cur_req = "R11"; clear_cfg(); set_rx(8, 29'h1555_0321 & 29'h1FFFFFFF, 0);
    send(29'h0AAA_A321 & 29'h1FFFFFFF, 0, 0, 0, 0); expect_idx("R11", 8);

    cur_req = "R2 random";
    for (int k = 0; k < 400; k++) begin
      clear_cfg();
      gid_mask = 29'($urandom) | 29'h0F0F0F0; gmed_mask0 = 8'($urandom); gmed_mask1 = 8'($urandom);
      for (int c = 0; c < N; c++) begin
        arb[c] = 29'($urandom % 8); c_ext[c] = 1'($urandom); c_tx[c] = 1'($urandom);
        c_gm[c] = 1'($urandom); c_me[c] = 1'($urandom);
        r0[c] = 8'($urandom % 4); r1[c] = 8'($urandom % 4);
      end
      frm_id = 29'($urandom % 8); frm_ext = 1'($urandom); frm_dlc = 4'($urandom);
      frm_b0 = 8'($urandom % 4); frm_b1 = 8'($urandom % 4);
      frm_valid = 1'($urandom);
      @(negedge clk);
    end
    frm_valid = 0;
    repeat (2) @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule